// File: doc/BRIEF.md
# Edge-Latched Interrupt Front End with Masking

This block gathers a bank of external event lines into a single level interrupt request. Each line is brought into the clock domain by a multi-flop synchronizer. A per-line polarity bit then selects whether a rising or a falling transition counts as an event. An event sets a sticky capture bit that stays set until software clears it, whatever the line does afterwards.

A mask register gates the capture bits into a pending vector. The OR of that vector appears as a flag in a status/control register. A master enable bit in the same register gates the flag onto the request output. Clearing the mask does not discard a captured event. Setting the mask again releases it as pending.

Software reaches the block through a small synchronous register port. A write takes effect at the clock edge where `bus_wr` is high. Reads are combinational from the current `bus_addr`. The register map is: 0 capture (read only), 1 clear (write-1-to-clear, reads 0), 2 mask, 3 pending (read only), 4 status/control, 5 polarity. Any other address reads 0.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the capture, mask, polarity and pending registers read 0, the status/control register reads 0 and `irq_out` is low.
- R2: Polarity bit i at address 5 selects the event for line i: 0 means a low-to-high change sets capture bit i, and 1 means a high-to-low change sets it. A change in the other direction, or a polarity write while the line is steady, leaves the capture bit at 0.
- R3: A capture bit set by an event holds while the line returns to its old level. Address 0 reports the capture bits and not the line levels. A line change driven before clock edge k is visible at address 0 after edge k+2.
- R4: Writing address 1 clears every capture bit whose data bit is 1. Capture bits whose data bit is 0 keep their value.
- R5: If an event on a line coincides with the clock edge that clears that line's capture bit, the capture bit ends up set.
- R6: Address 3 reads the capture bits ANDed with the mask at address 2, where 1 passes a line. Writing the mask to 0 keeps the capture bit, and setting the mask back to 1 makes the held event pending again.
- R7: At address 4, bit 2 is a read-only flag equal to the OR of the pending bits. Bit 3 is a read/write master enable. All other bits read 0, and a write to bit 2 has no effect.
- R8: `irq_out` is the flag ANDed with the master enable. It stays high as a level until the causing capture bits are cleared or masked, or the enable is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | N_LINES | External event lines, asynchronous |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data of the addressed register |
| irq_out | output | 1 | Level interrupt request |

## Verification
A capture bit stuck at 0 shows as a missing bit at address 0 three edges after the line change. The pending bit and `irq_out` are missing from that same edge on. A capture bit that fails to hold, or that follows the live line, shows as soon as the line is released and address 0 is read again. A wrong mask or enable shows up at address 3, at address 4 and on `irq_out` in the cycle after the write. A clear that beats a coincident event, or that touches a bit written as 0, shows as a missing bit on the next read.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
   localparam int ADDR_W   = 3;
   localparam int FLAG_BIT = 2;
   localparam int MEN_BIT  = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_CAPTURE = 3'd0,
      SEL_CLEAR   = 3'd1,
      SEL_MASK    = 3'd2,
      SEL_PEND    = 3'd3,
      SEL_STATUS  = 3'd4,
      SEL_POL     = 3'd5
   } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("irq_sync needs at least two stages");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] samp,
   input  logic [W-1:0] pol_fall,
   input  logic [W-1:0] clr,
   output logic [W-1:0] edge_hit,
   output logic [W-1:0] cap_q
);
   logic [W-1:0] prev_q;

   for (genvar i = 0; i < W; i++) begin : g_line
      logic rise, fall;
      assign rise = samp[i] & ~prev_q[i];
      assign fall = ~samp[i] & prev_q[i];
      assign edge_hit[i] = pol_fall[i] ? fall : rise;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cap_q  <= '0;
      end else begin
         prev_q <= samp;
         cap_q  <= (cap_q & ~clr) | edge_hit;
      end
   end
endmodule

// File: rtl/irq_regs.sv
module irq_regs
   import edge_irq_pkg::*;
#(
   parameter int N      = 8,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [N-1:0]      cap_q,
   input  logic [N-1:0]      pend,
   input  logic              flag,
   output logic [N-1:0]      mask_q,
   output logic [N-1:0]      pol_q,
   output logic              men_q,
   output logic [N-1:0]      clr,
   output logic [DATA_W-1:0] rdata
);
   reg_sel_e sel;
   assign sel = reg_sel_e'(addr);

   assign clr = (wr && sel == SEL_CLEAR) ? wdata[N-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         pol_q  <= '0;
         men_q  <= 1'b0;
      end else if (wr) begin
         case (sel)
            SEL_MASK:   mask_q <= wdata[N-1:0];
            SEL_POL:    pol_q  <= wdata[N-1:0];
            SEL_STATUS: men_q  <= wdata[MEN_BIT];
            default: ;
         endcase
      end
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CAPTURE: rdata[N-1:0] = cap_q;
         SEL_MASK:    rdata[N-1:0] = mask_q;
         SEL_PEND:    rdata[N-1:0] = pend;
         SEL_POL:     rdata[N-1:0] = pol_q;
         SEL_STATUS: begin
            rdata[FLAG_BIT] = flag;
            rdata[MEN_BIT]  = men_q;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int N_LINES     = 8,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_LINES-1:0] line_in,
   input  logic               bus_wr,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               irq_out
);
   if (N_LINES < 1 || N_LINES > DATA_W) begin : g_bad_lines
      $error("N_LINES must lie between 1 and DATA_W");
   end
   if (DATA_W <= MEN_BIT) begin : g_bad_width
      $error("DATA_W too narrow for the status/control bits");
   end

   logic [N_LINES-1:0] samp, edge_hit, cap_q, clr, mask_q, pol_q, pend;
   logic               men_q, flag;

   irq_sync #(.W(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(line_in), .q(samp)
   );

   irq_edge_latch #(.W(N_LINES)) u_cap (
      .clk(clk), .rst_n(rst_n), .samp(samp), .pol_fall(pol_q),
      .clr(clr), .edge_hit(edge_hit), .cap_q(cap_q)
   );

   assign pend = cap_q & mask_q;
   assign flag = |pend;

   irq_regs #(.N(N_LINES), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .cap_q(cap_q), .pend(pend), .flag(flag),
      .mask_q(mask_q), .pol_q(pol_q), .men_q(men_q), .clr(clr),
      .rdata(bus_rdata)
   );

   assign irq_out = flag & men_q;
endmodule

// File: rtl/edge_irq_ctrl_chk.sv
module edge_irq_ctrl_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [N-1:0] cap_q,
   input logic [N-1:0] clr,
   input logic [N-1:0] edge_hit,
   input logic [N-1:0] mask_q,
   input logic         men_q,
   input logic         irq_out
);
   // R3: a set capture bit without a clear stays set
   a_r3_capture_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (|(cap_q & ~clr)) |=> ((cap_q & $past(cap_q & ~clr)) == $past(cap_q & ~clr)));

   // R4: cleared bits with no coincident event drop
   a_r4_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr & ~edge_hit)) |=> ((cap_q & $past(clr & ~edge_hit)) == '0));

   // R5: an event always lands, even against a clear
   a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_hit) |=> ((cap_q & $past(edge_hit)) == $past(edge_hit)));

   // R6: masking never removes a capture bit by itself
   a_r6_mask_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(mask_q) && clr == '0) |-> ((cap_q & $past(cap_q)) == $past(cap_q)));

   // R8: request is high only with the enable set and a pending line
   a_r8_request_gated: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (men_q && (cap_q & mask_q) != '0));
endmodule

bind edge_irq_ctrl edge_irq_ctrl_chk #(.N(N_LINES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cap_q(cap_q), .clr(clr),
   .edge_hit(edge_hit), .mask_q(mask_q), .men_q(men_q), .irq_out(irq_out)
);

// File: tb/sim_edge_irq_ctrl.sv
module sim_edge_irq_ctrl;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [N-1:0] line_in = '0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   edge_irq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line_in), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out)
   );

   // {polarity, mask, enable, start level, end level, expected capture}
   localparam logic [47:0] VEC [7] = '{
      {8'h00, 8'hFF, 8'h01, 8'h00, 8'h0F, 8'h0F},
      {8'hFF, 8'hFF, 8'h01, 8'hFF, 8'hF0, 8'h0F},
      {8'h00, 8'h0F, 8'h01, 8'hFF, 8'h00, 8'h00},
      {8'hAA, 8'hF0, 8'h01, 8'h00, 8'hFF, 8'h55},
      {8'hAA, 8'h0A, 8'h01, 8'hFF, 8'h00, 8'hAA},
      {8'h00, 8'hFF, 8'h00, 8'h00, 8'h81, 8'h81},
      {8'h00, 8'h00, 8'h01, 8'h00, 8'h3C, 8'h3C}
   };

   task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); check("R1 capture", v, 8'h00);
      rd(3'd2, v); check("R1 mask", v, 8'h00);
      rd(3'd5, v); check("R1 polarity", v, 8'h00);
      rd(3'd3, v); check("R1 pending", v, 8'h00);
      rd(3'd4, v); check("R1 status", v, 8'h00);
      check("R1 irq", {7'd0, irq_out}, 8'h00);

      // vector table: R2, R6, R7, R8
      for (int k = 0; k < 7; k++) begin
         logic [7:0] pol, msk, men, st, fin, exp_cap, exp_pend, exp_stat;
         {pol, msk, men, st, fin, exp_cap} = VEC[k];
         exp_pend = exp_cap & msk;
         exp_stat = {4'd0, men[0], (exp_pend != 0), 2'd0};
         wr(3'd5, pol);
         wr(3'd2, msk);
         wr(3'd4, {4'd0, men[0], 3'd0});
         line_in = st;
         settle();
         wr(3'd1, 8'hFF);
         line_in = fin;
         settle();
         rd(3'd0, v); check("R2 capture by polarity", v, exp_cap);
         rd(3'd3, v); check("R6 pending", v, exp_pend);
         rd(3'd4, v); check("R7 status", v, exp_stat);
         check("R8 irq", {7'd0, irq_out}, {7'd0, exp_stat[3] & exp_stat[2]});
      end

      // clean slate, rising polarity, all masked in, enabled
      line_in = '0; settle();
      wr(3'd5, 8'h00); wr(3'd2, 8'hFF); wr(3'd4, 8'h08); wr(3'd1, 8'hFF);

      // R3 latency and hold
      @(negedge clk); line_in = 8'h01;
      @(negedge clk); @(negedge clk);
      rd(3'd0, v); check("R3 not yet after edge k+1", v, 8'h00);
      @(negedge clk);
      rd(3'd0, v); check("R3 visible after edge k+2", v, 8'h01);
      line_in = 8'h00; settle();
      rd(3'd0, v); check("R3 held after line drops", v, 8'h01);
      check("R8 level held", {7'd0, irq_out}, 8'h01);

      // R2 polarity write with steady line must not capture
      wr(3'd1, 8'hFF);
      line_in = 8'h02; settle(); wr(3'd1, 8'h02);
      wr(3'd5, 8'hFF); settle();
      rd(3'd0, v); check("R2 polarity change no capture", v, 8'h00);
      wr(3'd5, 8'h00);
      line_in = 8'h00; settle();

      // R4 partial clear
      line_in = 8'h0F; settle();
      wr(3'd1, 8'h05);
      rd(3'd0, v); check("R4 partial clear", v, 8'h0A);
      wr(3'd1, 8'h00);
      rd(3'd0, v); check("R4 zero write no effect", v, 8'h0A);
      line_in = 8'h00; wr(3'd1, 8'hFF); settle();

      // R5 event coincides with clear
      line_in = 8'h01; settle();
      line_in = 8'h00; settle();
      rd(3'd0, v); check("R5 precondition", v, 8'h01);
      line_in = 8'h01;
      @(negedge clk); @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h01;
      @(negedge clk); bus_wr = 1'b0;
      rd(3'd0, v); check("R5 event survives clear", v, 8'h01);
      line_in = 8'h00; settle(); wr(3'd1, 8'hFF);

      // R6 mask hold and release
      wr(3'd2, 8'h00);
      line_in = 8'h10; settle();
      rd(3'd3, v); check("R6 masked pending", v, 8'h00);
      check("R8 masked irq", {7'd0, irq_out}, 8'h00);
      rd(3'd0, v); check("R6 capture kept under mask", v, 8'h10);
      wr(3'd2, 8'h10);
      rd(3'd3, v); check("R6 released pending", v, 8'h10);
      check("R8 irq after unmask", {7'd0, irq_out}, 8'h01);

      // R7 flag is read-only, R8 enable drop
      wr(3'd4, 8'h04);
      rd(3'd4, v); check("R7 flag not writable", v, 8'h04);
      check("R8 disabled irq", {7'd0, irq_out}, 8'h00);
      wr(3'd1, 8'h10);
      rd(3'd4, v); check("R7 flag cleared", v, 8'h00);
      rd(3'd6, v); check("R7 unused address", v, 8'h00);

      finish_run();
   end
endmodule